// File: doc/BRIEF.md
# DMA Address and Count Sequencer

This block is the datapath of one ISA-style DMA channel. Software loads a 16-bit start address, a 16-bit count and an 8-bit page value. Each of these is held both as a base value and as a working value. Each accepted transfer strobe drives one 24-bit physical address for a single cycle. The working address then steps up or down, and the working count decrements. The count is held as transfers minus one, so a loaded zero means one transfer and 0xFFFF means 65536.

A parameter picks byte or word addressing. In byte mode the page supplies the top eight address bits above the 16-bit working address. In word mode the working address is shifted up one bit, bit 0 of the physical address is zero, and page bit 0 is unused. The page never receives a carry, so a run wraps inside its 64K or 128K window.

When the count wraps past zero, terminal count pulses. The channel then either reloads its working registers from the base values (auto-initialise) or masks itself. A masked channel ignores strobes.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset `bus_act` and `tc` are 0, `masked` is 1, `phys_addr` is 0 and `residue` is 1.
- R2: With WORD_MODE=0, the address driven on a transfer is `{page, working_address}`.
- R3: With WORD_MODE=1, the address driven is `{page[7:1], working_address, 1'b0}`. Page bit 0 has no effect.
- R4: After each transfer the working address steps by +1, or by -1 when the `ld_dec` value latched at load was 1. It wraps modulo 2^16, and the page bits never change.
- R5: `residue` equals the working count plus one, modulo 2^16. Each transfer lowers it by one, and it reads 0 after the last transfer of a non-auto run.
- R6: A count loaded as N yields exactly N+1 transfers. `tc` is high for one cycle, alongside `bus_act`, only on the last of them.
- R7: Without auto-initialise, terminal count sets `masked`, and later strobes produce no transfer and leave `residue` unchanged.
- R8: With auto-initialise, terminal count reloads the working address and count from the base values, and `masked` stays 0.
- R9: While `masked` is 1, a strobe produces no transfer. `mask_set` sets `masked` and `mask_clr` clears it.
- R10: Each accepted strobe gives exactly one one-cycle `bus_act` pulse. A strobe in the cycle after a transfer is ignored, so a held strobe transfers every other cycle.
- R11: `load` takes priority over a strobe in the same cycle: no transfer occurs, the working values take the loaded values, and `masked` is not changed by `load`.
- R12: When terminal count (without auto-initialise) and `mask_clr` fall in the same cycle, `masked` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load | input | 1 | Load base and working registers |
| ld_page | input | 8 | Page value |
| ld_addr | input | 16 | Start address |
| ld_count | input | 16 | Transfers minus one |
| ld_auto | input | 1 | Auto-initialise on terminal count |
| ld_dec | input | 1 | 1 = address decrements |
| mask_set | input | 1 | Set the channel mask |
| mask_clr | input | 1 | Clear the channel mask |
| xfer | input | 1 | Transfer strobe |
| bus_act | output | 1 | One-cycle transfer cycle indicator |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc | output | 1 | Terminal count pulse |
| residue | output | 16 | Working count plus one |
| masked | output | 1 | Channel mask state |

## Verification
Terminal count and a software mask clear can land on the same clock edge. The bench provokes this by raising `mask_clr` together with the strobe of the final transfer of a non-auto run. It then requires `masked` to read 1 and a following strobe to produce no `bus_act`. A second collision, `load` arriving with a strobe, is judged by the absence of a transfer and by `residue` showing the new count.

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter bit WORD_MODE = 1'b0,
  parameter int AW = 16,
  parameter int PW = 8,
  localparam int PA = AW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] ld_page,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_count,
  input  logic          ld_auto,
  input  logic          ld_dec,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          xfer,
  output logic          bus_act,
  output logic [PA-1:0] phys_addr,
  output logic          tc,
  output logic [AW-1:0] residue,
  output logic          masked
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [PW-1:0] page_q;
  logic [AW-1:0] base_addr, base_cnt, cur_addr, cur_cnt;
  logic          auto_q, dec_q, mask_q;
  logic [PA-1:0] addr_map;

  wire go   = xfer && !mask_q && !bus_act && !load;
  wire last = (cur_cnt == '0);
  wire [AW-1:0] step_addr = dec_q ? cur_addr - ONE : cur_addr + ONE;

  generate
    if (WORD_MODE) begin : g_word
      assign addr_map = {page_q[PW-1:1], cur_addr, 1'b0};
    end else begin : g_byte
      assign addr_map = {page_q, cur_addr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      auto_q    <= 1'b0;
      dec_q     <= 1'b0;
      mask_q    <= 1'b1;
      bus_act   <= 1'b0;
      tc        <= 1'b0;
      phys_addr <= '0;
    end else begin
      bus_act <= go;
      tc      <= go && last;
      if (go) phys_addr <= addr_map;

      if (load) begin
        page_q    <= ld_page;
        base_addr <= ld_addr;
        base_cnt  <= ld_count;
        cur_addr  <= ld_addr;
        cur_cnt   <= ld_count;
        auto_q    <= ld_auto;
        dec_q     <= ld_dec;
      end else if (go) begin
        if (last && auto_q) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= step_addr;
          cur_cnt  <= cur_cnt - ONE;
        end
      end

      if (mask_set || (go && last && !auto_q)) mask_q <= 1'b1;
      else if (mask_clr)                       mask_q <= 1'b0;
    end
  end

  assign residue = cur_cnt + ONE;
  assign masked  = mask_q;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter bit WORD_MODE = 1'b0,
  parameter int AW = 16,
  parameter int PA = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_act,
  input logic          tc,
  input logic          masked,
  input logic          auto_q,
  input logic [AW-1:0] residue,
  input logic [PA-1:0] phys_addr
);
  a_r6_tc_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> bus_act);

  a_r6_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |=> !bus_act);

  a_r9_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !bus_act);

  a_r7_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_q) |-> masked);

  a_r5_residue_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !tc) |-> residue == AW'($past(residue) - 1'b1));

  generate
    if (WORD_MODE) begin : g_w
      a_r3_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |-> !phys_addr[0]);
    end
  endgenerate
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.WORD_MODE(WORD_MODE), .AW(AW), .PA(PA)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .tc(tc), .masked(masked),
  .auto_q(auto_q), .residue(residue), .phys_addr(phys_addr)
);

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, ld_auto = 0, ld_dec = 0, mask_set = 0, mask_clr = 0, xfer = 0;
  logic [7:0]  ld_page = '0;
  logic [15:0] ld_addr = '0, ld_count = '0;
  logic        bus_act, tc, masked, bus_act_w, tc_w, masked_w;
  logic [23:0] phys_addr, phys_addr_w;
  logic [15:0] residue, residue_w;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_addr_seq #(.WORD_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .ld_auto(ld_auto), .ld_dec(ld_dec), .mask_set(mask_set),
    .mask_clr(mask_clr), .xfer(xfer), .bus_act(bus_act), .phys_addr(phys_addr),
    .tc(tc), .residue(residue), .masked(masked));

  dma_addr_seq #(.WORD_MODE(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .ld_auto(ld_auto), .ld_dec(ld_dec), .mask_set(mask_set),
    .mask_clr(mask_clr), .xfer(xfer), .bus_act(bus_act_w), .phys_addr(phys_addr_w),
    .tc(tc_w), .residue(residue_w), .masked(masked_w));

  // page, addr, count, dec, first phys, second phys, residue after two
  localparam int NV = 6;
  localparam logic [107:0] VEC [NV] = '{
    {8'h12, 16'h3456, 16'h0005, 4'h0, 24'h123456, 24'h123457, 16'h0004},
    {8'h12, 16'h3456, 16'h0005, 4'h1, 24'h123456, 24'h123455, 16'h0004},
    {8'h7F, 16'hFFFF, 16'h0010, 4'h0, 24'h7FFFFF, 24'h7F0000, 16'h000F},
    {8'h80, 16'h0000, 16'h0010, 4'h1, 24'h800000, 24'h80FFFF, 16'h000F},
    {8'h00, 16'hABCD, 16'hFFFF, 4'h0, 24'h00ABCD, 24'h00ABCE, 16'hFFFE},
    {8'hFF, 16'h1234, 16'h0003, 4'h1, 24'hFF1234, 24'hFF1233, 16'h0002}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] p, input logic [15:0] a, input logic [15:0] c,
                         input logic au, input logic dc, input logic clr);
    @(negedge clk);
    load = 1; ld_page = p; ld_addr = a; ld_count = c; ld_auto = au; ld_dec = dc; mask_clr = clr;
    @(negedge clk);
    load = 0; mask_clr = 0;
  endtask

  task automatic pulse(input logic clr);
    @(negedge clk);
    xfer = 1; mask_clr = clr;
    @(negedge clk);
    xfer = 0; mask_clr = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1 bus_act", bus_act, 0);
    chk("R1 tc", tc, 0);
    chk("R1 masked", masked, 1);
    chk("R1 phys", phys_addr, 0);
    chk("R1 residue", residue, 1);
    rst_n = 1;

    // R9: masked after reset, strobe ignored
    pulse(0);
    chk("R9 masked strobe", bus_act, 0);

    // R2 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][107:100], VEC[i][99:84], VEC[i][83:68], 1'b0, VEC[i][64], 1'b1);
      pulse(0);
      chk("R2 first phys", phys_addr, VEC[i][63:40]);
      chk("R10 bus_act", bus_act, 1);
      pulse(0);
      chk("R4 second phys", phys_addr, VEC[i][39:16]);
      chk("R5 residue", residue, VEC[i][15:0]);
    end

    // R3 word mode, page bit 0 ignored, wrap in 128K window
    do_load(8'h13, 16'h8001, 16'h0004, 1'b0, 1'b0, 1'b1);
    pulse(0);
    chk("R3 word phys p13", phys_addr_w, 24'h130002);
    do_load(8'h12, 16'h8001, 16'h0004, 1'b0, 1'b0, 1'b1);
    pulse(0);
    chk("R3 word phys p12", phys_addr_w, 24'h130002);
    do_load(8'h12, 16'hFFFF, 16'h0004, 1'b0, 1'b0, 1'b1);
    pulse(0);
    chk("R3 word wrap a", phys_addr_w, 24'h13FFFE);
    pulse(0);
    chk("R3 word wrap b", phys_addr_w, 24'h120000);

    // R6 R7 R12: count 2 -> three transfers, mask_clr on the last
    do_load(8'h20, 16'h0010, 16'h0002, 1'b0, 1'b0, 1'b1);
    pulse(0);
    chk("R6 tc early 1", tc, 0);
    pulse(0);
    chk("R6 tc early 2", tc, 0);
    pulse(1);
    chk("R6 tc last", tc, 1);
    chk("R5 residue zero", residue, 0);
    chk("R12 mask wins", masked, 1);
    @(negedge clk);
    chk("R6 tc one cycle", tc, 0);
    pulse(0);
    chk("R7 no transfer", bus_act, 0);
    chk("R7 residue held", residue, 0);
    chk("R7 phys held", phys_addr, 24'h200012);

    // R8 auto-initialise
    do_load(8'h05, 16'h0100, 16'h0001, 1'b1, 1'b0, 1'b1);
    pulse(0);
    chk("R8 phys 1", phys_addr, 24'h050100);
    pulse(0);
    chk("R8 phys 2", phys_addr, 24'h050101);
    chk("R8 tc", tc, 1);
    chk("R8 reload residue", residue, 2);
    chk("R8 not masked", masked, 0);
    pulse(0);
    chk("R8 phys after reload", phys_addr, 24'h050100);

    // R10 held strobe
    do_load(8'h01, 16'h0000, 16'h0010, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    xfer = 1; cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (bus_act) cnt++;
    end
    xfer = 0;
    chk("R10 held count", cnt, 2);
    chk("R10 residue", residue, 16'h000F);

    // R11 load beats strobe
    @(negedge clk);
    load = 1; xfer = 1; ld_page = 8'h33; ld_addr = 16'h4444; ld_count = 16'h0007; ld_auto = 0; ld_dec = 0;
    @(negedge clk);
    load = 0; xfer = 0;
    chk("R11 no transfer", bus_act, 0);
    chk("R11 residue", residue, 16'h0008);
    chk("R11 mask kept", masked, 0);

    // R9 mask_set blocks
    @(negedge clk);
    mask_set = 1;
    @(negedge clk);
    mask_set = 0;
    chk("R9 masked", masked, 1);
    pulse(0);
    chk("R9 no transfer", bus_act, 0);
    chk("R9 residue held", residue, 16'h0008);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule